// File: doc/BRIEF.md
# Banked GPIO Controller with Masked Output Writes

This block is a memory-mapped general-purpose I/O controller holding four banks of 32 pins each. Software reaches it through a simple single-cycle register port: a write strobe with an address and data, plus a combinational read-data return for the presented address. Each bank has a direction control, a separate output-enable control, an output data register and a read-only view of the synchronised pin levels. Either 16-bit half of a bank's output data can be updated through a masked-write register, so one bit can be set or cleared without a read-modify-write.

Every bank also contains an interrupt unit. For each pin it selects level or edge detection, the active polarity, and whether both edges count. Detected events latch into a status register that software clears by writing ones. A mask register, changed only through separate enable and disable registers, decides which status bits reach the single combined interrupt output. Pins 0 to 53 and 64 to 127 exist. Pin indices 54 to 63, which are bits 22 to 31 of bank 1, do not exist and always read as zero.

Top module: `banked_gpio`

## Requirements
- R1: After reset the pin enables, the output data, direction, output-enable, type, polarity and any-edge registers are zero, the interrupt output is low, and the mask register of every bank reads ones on all of its existing pins.
- R2: A write to 0x000+8*b updates bank b output bits 15:0, and a write to 0x004+8*b updates bits 31:16. Bits 31:16 of the write data are a per-bit inhibit. Where an inhibit bit is 0, the output bit takes the matching bit from write data bits 15:0. Where it is 1, the output bit keeps its value. The other half of the bank is left unchanged.
- R3: The output data register at 0x040+4*b can be written and read back, and it drives pin_out bits 32*b+31 to 32*b.
- R4: The direction register is at 0x204+0x40*b and the output-enable register is at 0x208+0x40*b. pin_oe for a pin is 1 only when both its direction bit and its output-enable bit are 1.
- R5: The input register at 0x060+4*b returns the pin levels through a two-flop synchroniser. A pin change is not visible after one clock edge, and it is visible after two.
- R6: The mask register at 0x20C+0x40*b is read-only. Writing 1 to a bit at 0x210+0x40*b clears that mask bit. Writing 1 to a bit at 0x214+0x40*b sets that mask bit.
- R7: Edge mode is selected by a 1 in the type register at 0x21C+0x40*b. In edge mode, a polarity bit (0x220+0x40*b) of 1 selects rising edges and 0 selects falling edges. An any-edge bit (0x224+0x40*b) of 1 makes both edges count. Status bits at 0x218+0x40*b stay set until software writes 1 to them.
- R8: Level mode is selected by a 0 in the type register. In level mode, a status bit is set on every cycle in which the synchronised pin equals its polarity bit. A write-1 clear does not take effect while the level condition holds.
- R9: irq is high exactly when some bank has a status bit set whose mask bit is 0.
- R10: Reads of unmapped offsets, and of bits 22 to 31 of bank 1, return zero. Writes to unmapped offsets and to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 128 | Pad input levels |
| pin_out | output | 128 | Pad output values |
| pin_oe | output | 128 | Pad drive enables, 1 drives and 0 tristates |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check several properties on every cycle. A masked write leaves inhibited bits and the other half of the bank untouched. A status bit never drops unless a clear write is made. An enable write clears the written mask bits. The bits of the missing pins stay at zero in every register. Only the bench's scenarios can show the absolute register offsets and the two-edge synchroniser delay. They also show how rising, falling and any-edge selections differ, that a level clear is refused while the level holds, and how the combined interrupt follows mask and status.

// File: rtl/gpio_pkg.sv
// Shared constants and helpers for the banked GPIO controller.
// Assumes 32-bit banks and byte offsets that fit the register port.
package gpio_pkg;
    localparam int DW   = 32;
    localparam int HALF = DW / 2;
    typedef logic [DW-1:0] word_t;

    // Per-bank register offsets and strides
    localparam int OFF_MLO   = 'h000;
    localparam int OFF_MHI   = 'h004;
    localparam int STEP_M    = 8;
    localparam int OFF_DATA  = 'h040;
    localparam int OFF_DIN   = 'h060;
    localparam int STEP_D    = 4;
    localparam int OFF_DIR   = 'h204;
    localparam int OFF_OE    = 'h208;
    localparam int OFF_IMSK  = 'h20C;
    localparam int OFF_IEN   = 'h210;
    localparam int OFF_IDIS  = 'h214;
    localparam int OFF_ISTAT = 'h218;
    localparam int OFF_ITYPE = 'h21C;
    localparam int OFF_IPOL  = 'h220;
    localparam int OFF_IANY  = 'h224;
    localparam int STEP_C    = 'h40;

    // Which bits of a bank map to an existing pin
    function automatic word_t valid_bits(int bank, int lo_pins, int hi_base);
        word_t v;
        for (int i = 0; i < DW; i++) begin
            v[i] = ((bank * DW + i) < lo_pins) || ((bank * DW + i) >= hi_base);
        end
        return v;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for the pad inputs.
// Assumes each bit is an independent, slowly changing level.
module gpio_sync #(
    parameter int W = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    // Two-stage capture of the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// One 32-pin bank: output data with masked half-word updates, direction,
// output enable and the interrupt detector. Write strobes come decoded
// and one-hot. VMASK marks bits that map to existing pins; all other bits
// are held at zero.
module gpio_bank
    import gpio_pkg::*;
#(
    parameter word_t VMASK = '1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  word_t wdata,
    input  logic  we_mlo,
    input  logic  we_mhi,
    input  logic  we_data,
    input  logic  we_dir,
    input  logic  we_oe,
    input  logic  we_ien,
    input  logic  we_idis,
    input  logic  we_istat,
    input  logic  we_itype,
    input  logic  we_ipol,
    input  logic  we_iany,
    input  word_t pin_s,
    output word_t dout,
    output word_t dir,
    output word_t oe,
    output word_t imask,
    output word_t istat,
    output word_t itype,
    output word_t ipol,
    output word_t iany,
    output logic  irq_b
);
    word_t dout_nx, prev, rise, fall, hit;

    // Next output data from a full write or a masked half write
    always_comb begin
        dout_nx = dout;
        if (we_data) dout_nx = wdata;
        if (we_mlo)
            dout_nx[HALF-1:0] = (dout[HALF-1:0] & wdata[DW-1:HALF])
                              | (wdata[HALF-1:0] & ~wdata[DW-1:HALF]);
        if (we_mhi)
            dout_nx[DW-1:HALF] = (dout[DW-1:HALF] & wdata[DW-1:HALF])
                               | (wdata[HALF-1:0] & ~wdata[DW-1:HALF]);
    end

    // Output data and plain configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= '0;
            dir   <= '0;
            oe    <= '0;
            itype <= '0;
            ipol  <= '0;
            iany  <= '0;
        end else begin
            dout <= dout_nx & VMASK;
            if (we_dir)   dir   <= wdata & VMASK;
            if (we_oe)    oe    <= wdata & VMASK;
            if (we_itype) itype <= wdata & VMASK;
            if (we_ipol)  ipol  <= wdata & VMASK;
            if (we_iany)  iany  <= wdata & VMASK;
        end
    end

    // Interrupt mask, changed only through enable and disable writes
    always_ff @(posedge clk) begin
        if (!rst_n)       imask <= VMASK;
        else if (we_ien)  imask <= imask & ~wdata;
        else if (we_idis) imask <= (imask | wdata) & VMASK;
    end

    // Previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= pin_s;
    end

    // Per-pin event detection by type, polarity and any-edge
    always_comb begin
        rise = pin_s & ~prev;
        fall = ~pin_s & prev;
        for (int i = 0; i < DW; i++) begin
            if (!itype[i])     hit[i] = ~(pin_s[i] ^ ipol[i]);
            else if (iany[i])  hit[i] = rise[i] | fall[i];
            else               hit[i] = ipol[i] ? rise[i] : fall[i];
        end
    end

    // Sticky status with write-one clear; a new event wins over the clear
    always_ff @(posedge clk) begin
        if (!rst_n) istat <= '0;
        else        istat <= ((istat & ~(we_istat ? wdata : '0)) | hit) & VMASK;
    end

    assign irq_b = |(istat & ~imask);

    // R2: a low-half masked write keeps inhibited bits and the high half
    p_mlo_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_mlo |=> (((dout[HALF-1:0] ^ $past(dout[HALF-1:0])) & $past(wdata[DW-1:HALF])) == '0)
                   && (dout[DW-1:HALF] == $past(dout[DW-1:HALF])));

    // R2: a high-half masked write leaves the low half alone
    p_mhi_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_mhi |=> dout[HALF-1:0] == $past(dout[HALF-1:0]));

    // R6: an enable write clears every written mask bit
    p_ien_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        we_ien |=> (imask & $past(wdata)) == '0);

    // R7: status bits only drop when a clear write is made
    p_stat_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we_istat |=> (istat & $past(istat)) == $past(istat));

    // R10: bits of missing pins stay zero in every register
    p_invalid_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((dout | dir | oe | imask | istat | itype | ipol | iany) & ~VMASK) == '0);
endmodule

// File: rtl/banked_gpio.sv
// Top of the banked GPIO controller: register decode, read multiplexer,
// input synchroniser, pad drive and the combined interrupt.
// Assumes one register access per cycle and reads that are free of side effects.
module banked_gpio
    import gpio_pkg::*;
#(
    parameter int NBANK    = 4,
    parameter int ADDR_W   = 12,
    parameter int LO_PINS  = 54,
    parameter int HI_BASE  = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NBANK*DW-1:0] pin_in,
    output logic [NBANK*DW-1:0] pin_out,
    output logic [NBANK*DW-1:0] pin_oe,
    output logic                irq
);
    localparam int NPIN = NBANK * DW;

    logic [NPIN-1:0] pin_s;
    word_t dout_a[NBANK], dir_a[NBANK], oe_a[NBANK], imsk_a[NBANK];
    word_t stat_a[NBANK], type_a[NBANK], pol_a[NBANK], any_a[NBANK];
    logic [NBANK-1:0] irq_v;

    gpio_sync #(.W(NPIN)) u_sync (.clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s));

    // Address decode per bank, bank instances and pad drive
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam word_t VM = valid_bits(b, LO_PINS, HI_BASE);

        gpio_bank #(.VMASK(VM)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wdata   (bus_wdata),
            .we_mlo  (bus_we && bus_addr == ADDR_W'(OFF_MLO   + STEP_M * b)),
            .we_mhi  (bus_we && bus_addr == ADDR_W'(OFF_MHI   + STEP_M * b)),
            .we_data (bus_we && bus_addr == ADDR_W'(OFF_DATA  + STEP_D * b)),
            .we_dir  (bus_we && bus_addr == ADDR_W'(OFF_DIR   + STEP_C * b)),
            .we_oe   (bus_we && bus_addr == ADDR_W'(OFF_OE    + STEP_C * b)),
            .we_ien  (bus_we && bus_addr == ADDR_W'(OFF_IEN   + STEP_C * b)),
            .we_idis (bus_we && bus_addr == ADDR_W'(OFF_IDIS  + STEP_C * b)),
            .we_istat(bus_we && bus_addr == ADDR_W'(OFF_ISTAT + STEP_C * b)),
            .we_itype(bus_we && bus_addr == ADDR_W'(OFF_ITYPE + STEP_C * b)),
            .we_ipol (bus_we && bus_addr == ADDR_W'(OFF_IPOL  + STEP_C * b)),
            .we_iany (bus_we && bus_addr == ADDR_W'(OFF_IANY  + STEP_C * b)),
            .pin_s   (pin_s[b*DW +: DW]),
            .dout    (dout_a[b]),
            .dir     (dir_a[b]),
            .oe      (oe_a[b]),
            .imask   (imsk_a[b]),
            .istat   (stat_a[b]),
            .itype   (type_a[b]),
            .ipol    (pol_a[b]),
            .iany    (any_a[b]),
            .irq_b   (irq_v[b])
        );

        assign pin_out[b*DW +: DW] = dout_a[b];
        assign pin_oe[b*DW +: DW]  = dir_a[b] & oe_a[b];
    end

    // Read multiplexer; unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (bus_addr == ADDR_W'(OFF_DATA  + STEP_D * b)) bus_rdata = dout_a[b];
            if (bus_addr == ADDR_W'(OFF_DIN   + STEP_D * b))
                bus_rdata = pin_s[b*DW +: DW] & valid_bits(b, LO_PINS, HI_BASE);
            if (bus_addr == ADDR_W'(OFF_DIR   + STEP_C * b)) bus_rdata = dir_a[b];
            if (bus_addr == ADDR_W'(OFF_OE    + STEP_C * b)) bus_rdata = oe_a[b];
            if (bus_addr == ADDR_W'(OFF_IMSK  + STEP_C * b)) bus_rdata = imsk_a[b];
            if (bus_addr == ADDR_W'(OFF_ISTAT + STEP_C * b)) bus_rdata = stat_a[b];
            if (bus_addr == ADDR_W'(OFF_ITYPE + STEP_C * b)) bus_rdata = type_a[b];
            if (bus_addr == ADDR_W'(OFF_IPOL  + STEP_C * b)) bus_rdata = pol_a[b];
            if (bus_addr == ADDR_W'(OFF_IANY  + STEP_C * b)) bus_rdata = any_a[b];
        end
    end

    assign irq = |irq_v;

    // R9: the combined interrupt can only be raised while some bank requests it
    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_v != '0);
endmodule

// File: tb/sim_banked_gpio.sv
// Scoreboard bench: driver tasks queue expected items, a monitor on the
// falling edge pops and compares them against the design's outputs.
module sim_banked_gpio;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] pin_in = '0;
    logic [127:0] pin_out, pin_oe;
    logic         irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 read data, 1 pin_out bank, 2 pin_oe bank, 3 irq
        int          bank;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    always #5 clk = ~clk;

    banked_gpio u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Monitor: compare one queued expectation per falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = bus_rdata;
                1:       act = pin_out[it.bank*32 +: 32];
                2:       act = pin_oe[it.bank*32 +: 32];
                default: act = {31'b0, irq};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        bus_addr = a;
        q.push_back('{0, 0, e, tag});
    endtask

    task automatic chk(input int kind, input int bank, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        q.push_back('{kind, bank, e, tag});
    endtask

    task automatic set_bank(input int bank, input logic [31:0] v);
        @(posedge clk); #1;
        pin_in[bank*32 +: 32] = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        idle(3); #1; rst_n = 1'b1;
        // R1 reset state
        rd(12'h20C, 32'hFFFF_FFFF, "R1 mask bank0");
        rd(12'h24C, 32'h003F_FFFF, "R1 mask bank1");
        rd(12'h204, 32'h0, "R1 dir bank0");
        rd(12'h040, 32'h0, "R1 data bank0");
        chk(2, 0, 32'h0, "R1 pin_oe bank0");
        chk(3, 0, 32'h0, "R1 irq");
        // R8 level-low default latches on low pins
        rd(12'h218, 32'hFFFF_FFFF, "R8 level-low status bank0");
        // R3 data register
        wr(12'h040, 32'hA5A5_1234);
        rd(12'h040, 32'hA5A5_1234, "R3 data readback");
        chk(1, 0, 32'hA5A5_1234, "R3 pin_out bank0");
        // R2 masked writes
        wr(12'h000, 32'hFF00_00FF);
        rd(12'h040, 32'hA5A5_12FF, "R2 low half masked");
        wr(12'h004, 32'hFFFE_0000);
        rd(12'h040, 32'hA5A4_12FF, "R2 high half clear bit16");
        wr(12'h014, 32'h0000_BEEF);
        rd(12'h048, 32'hBEEF_0000, "R2 bank2 high half unmasked");
        // R4 drive enable
        wr(12'h204, 32'h0000_00FF);
        wr(12'h208, 32'h0000_F00F);
        chk(2, 0, 32'h0000_000F, "R4 pin_oe needs dir and oe");
        // R5 synchroniser depth
        set_bank(2, 32'hDEAD_BEEF);
        rd(12'h068, 32'h0, "R5 not visible after one edge");
        rd(12'h068, 32'hDEAD_BEEF, "R5 visible after two edges");
        // R7 edge detection on bank3
        wr(12'h2DC, 32'hFFFF_FFFF);
        wr(12'h2E0, 32'h0000_0001);
        wr(12'h2E4, 32'h0000_0004);
        wr(12'h2D8, 32'hFFFF_FFFF);
        rd(12'h2D8, 32'h0, "R7 status cleared");
        set_bank(3, 32'h7);
        idle(4);
        rd(12'h2D8, 32'h5, "R7 rising and any-edge");
        set_bank(3, 32'h0);
        idle(4);
        rd(12'h2D8, 32'h7, "R7 falling added");
        wr(12'h2D8, 32'h1);
        rd(12'h2D8, 32'h6, "R7 write-one clear");
        // R9 and R6 combined interrupt and mask
        chk(3, 0, 32'h0, "R9 irq low while masked");
        wr(12'h2D0, 32'h2);
        chk(3, 0, 32'h1, "R9 irq after enable");
        rd(12'h2CC, 32'hFFFF_FFFD, "R6 enable clears mask bit");
        wr(12'h2CC, 32'h0);
        rd(12'h2CC, 32'hFFFF_FFFD, "R6 mask is read-only");
        wr(12'h2D8, 32'h2);
        chk(3, 0, 32'h0, "R9 irq low after clear");
        rd(12'h2D8, 32'h4, "R7 other status kept");
        wr(12'h2D4, 32'h2);
        rd(12'h2CC, 32'hFFFF_FFFF, "R6 disable sets mask bit");
        // R8 level-high and refused clear
        wr(12'h220, 32'h0000_0020);
        wr(12'h218, 32'hFFFF_FFFF);
        rd(12'h218, 32'hFFFF_FFDF, "R8 clear refused while level holds");
        set_bank(0, 32'h0000_0020);
        idle(4);
        rd(12'h218, 32'hFFFF_FFFF, "R8 level-high sets status");
        // R10 missing pins and unmapped offsets
        wr(12'h044, 32'hFFFF_FFFF);
        rd(12'h044, 32'h003F_FFFF, "R10 bank1 missing data bits");
        chk(1, 1, 32'h003F_FFFF, "R10 pin_out missing pins");
        set_bank(1, 32'hFFFF_FFFF);
        idle(3);
        rd(12'h064, 32'h003F_FFFF, "R10 bank1 missing input bits");
        wr(12'h300, 32'hFFFF_FFFF);
        rd(12'h300, 32'h0, "R10 unmapped read zero");
        rd(12'h040, 32'hA5A4_12FF, "R10 unmapped write ignored");
        idle(2);
        done = 1;
        summary();
    end
endmodule